// File: doc/BRIEF.md
# Six-Input Trigger Coincidence Table with Veto

This block turns six conditioned trigger levels into a trigger decision. The six levels form a 6-bit index. That index selects one bit of a 64-bit programmable table, and the selected bit says whether the present input combination counts as a trigger. Because any set of the 64 combinations can be marked as valid, the table expresses any coincidence, anti-coincidence or OR condition over the six inputs.

A trigger is recognised on the cycle where the selected table bit turns from 0 to 1. A combination held for many cycles therefore produces only one trigger. A veto bit stops triggers from being issued. Two saturating counters track the triggers: one counts every recognised trigger whether or not the veto is set, and the other counts only the triggers actually issued.

Software loads the table through a 32-bit register port, one half at a time. A separate 64-bit load port writes the whole table in a single cycle.

Top module: `trig_combine`

## Requirements
- R1: After reset the table is all zeros, the veto bit reads 1, both counters read 0 and `trig_pulse` is low.
- R2: Index bit i is `trig_in[i]`, with `trig_in[0]` as the least significant bit. A combination matches when table bit `{trig_in[5:0]}` is 1.
- R3: A write to `cfg_addr` 0 replaces table bits 31..0 and a write to address 1 replaces bits 63..32. Reading the same addresses returns those halves on `cfg_rdata` in the same cycle.
- R4: When `mask_load` is high, `mask_word` replaces the whole table at the clock edge. If a half write happens in the same cycle, the full load takes priority.
- R5: A match that stays high over several cycles gives one trigger and adds one to each counter that is allowed to count it.
- R6: `trig_pulse` is high for exactly one cycle. If the matching inputs are present before clock edge k, the pulse is high between edge k+1 and edge k+2.
- R7: While the veto bit is 1, no pulse is issued, but the pre-veto counter still counts the trigger.
- R8: The post-veto counter counts a trigger only when the veto bit is 0 in the cycle the trigger is recognised.
- R9: Both counters stop at all-ones and stay there.
- R10: Any write to `cfg_addr` 3 clears both counters at that edge. This clear takes priority over an increment in the same cycle.
- R11: Bit 0 of a write to `cfg_addr` 2 sets the veto bit, and the same address reads it back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | N_IN | Conditioned trigger levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| mask_load | input | 1 | Load the whole table from `mask_word` |
| mask_word | input | 64 | Full table value |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| pre_cnt | output | CNT_W | Triggers recognised, counted regardless of veto |
| post_cnt | output | CNT_W | Triggers issued while the veto bit was 0 |

## Verification
The main function is checked with a table whose set bits lie in both halves, including the top entry 63. It is driven with single-bit patterns, a two-bit pattern and the all-ones pattern, together with near neighbours that must not match. A bit-order error or a half-word swap shows up as a wrong pulse on one of these neighbours. A combination held for several cycles separates edge detection from level detection. Alternating match and idle in a tight loop drives the counters into saturation. Timing the counter-clear write to land on the cycle of a trigger tests the clear-over-increment priority.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int N_IN     = 6;
    localparam int TBL_W    = 1 << N_IN;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int N_HALF   = TBL_W / REG_W;

    localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_VETO    = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd3;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              mask_load,
    input  logic [TBL_W-1:0]  mask_word,
    output logic [TBL_W-1:0]  mask,
    output logic              veto,
    output logic              cnt_clr,
    output logic [REG_W-1:0]  cfg_rdata
);
    typedef struct packed {
        logic [TBL_W-1:0] mask;
        logic             veto;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [REG_W-1:0] half_rd [N_HALF];

    for (genvar h = 0; h < N_HALF; h++) begin : g_half_rd
        assign half_rd[h] = st_q.mask[h*REG_W +: REG_W];
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int h = 0; h < N_HALF; h++) begin
                if (cfg_addr == (A_MASK_LO + ADDR_W'(h)))
                    st_d.mask[h*REG_W +: REG_W] = cfg_wdata;
            end
            if (cfg_addr == A_VETO)
                st_d.veto = cfg_wdata[0];
        end
        if (mask_load)
            st_d.mask = mask_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '0;
            st_q.veto <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int h = 0; h < N_HALF; h++) begin
            if (cfg_addr == (A_MASK_LO + ADDR_W'(h)))
                cfg_rdata = half_rd[h];
        end
        if (cfg_addr == A_VETO)
            cfg_rdata = {{(REG_W-1){1'b0}}, st_q.veto};
    end

    assign mask    = st_q.mask;
    assign veto    = st_q.veto;
    assign cnt_clr = cfg_we && (cfg_addr == A_CLEAR);
endmodule

// File: rtl/trig_lut_match.sv
module trig_lut_match
    import trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  trig_in,
    input  logic [TBL_W-1:0] mask,
    input  logic             veto,
    output logic             match,
    output logic             rise,
    output logic             pulse
);
    typedef struct packed {
        logic match;
        logic prev;
        logic pulse;
    } det_t;

    det_t st_d, st_q;
    logic hit;

    always_comb begin
        hit        = mask[trig_in];
        st_d.match = hit;
        st_d.prev  = st_q.match;
        st_d.pulse = st_q.match && !st_q.prev && !veto;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match = st_q.match;
    assign rise  = st_q.match && !st_q.prev;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/trig_sat_counter.sv
module trig_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (inc && st_q.cnt != TOP)
            st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/trig_combine.sv
module trig_combine
    import trig_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   trig_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              mask_load,
    input  logic [TBL_W-1:0]  mask_word,
    output logic              trig_pulse,
    output logic [CNT_W-1:0]  pre_cnt,
    output logic [CNT_W-1:0]  post_cnt
);
    logic [TBL_W-1:0] mask_w;
    logic             veto_w;
    logic             clr_w;
    logic             match_w;
    logic             rise_w;
    logic             inc_pre;
    logic             inc_post;

    trig_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mask_load (mask_load),
        .mask_word (mask_word),
        .mask      (mask_w),
        .veto      (veto_w),
        .cnt_clr   (clr_w),
        .cfg_rdata (cfg_rdata)
    );

    trig_lut_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .mask    (mask_w),
        .veto    (veto_w),
        .match   (match_w),
        .rise    (rise_w),
        .pulse   (trig_pulse)
    );

    assign inc_pre  = rise_w;
    assign inc_post = rise_w && !veto_w;

    trig_sat_counter #(.W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_w),
        .inc   (inc_pre),
        .cnt   (pre_cnt)
    );

    trig_sat_counter #(.W(CNT_W)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_w),
        .inc   (inc_post),
        .cnt   (post_cnt)
    );
endmodule

// File: rtl/trig_combine_chk.sv
module trig_combine_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_pulse,
    input logic [CNT_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] post_cnt,
    input logic             veto,
    input logic             clr,
    input logic             match
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    // R6: the pulse never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R5: a pulse follows a registered match
    a_r5_pulse_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(match));

    // R7: no pulse when the veto was set on the deciding cycle
    a_r7_veto_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> !$past(veto));

    // R8: the post-veto count only rises together with an issued pulse
    a_r8_post_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (post_cnt != $past(post_cnt) && !$past(clr)) |-> trig_pulse);

    // R9: a saturated counter stays saturated
    a_r9_pre_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pre_cnt) == ALL1 && !$past(clr)) |-> pre_cnt == ALL1);

    // R10: a clear write empties both counters
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (pre_cnt == '0 && post_cnt == '0));
endmodule

bind trig_combine trig_combine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_pulse (trig_pulse),
    .pre_cnt    (pre_cnt),
    .post_cnt   (post_cnt),
    .veto       (veto_w),
    .clr        (clr_w),
    .match      (match_w)
);

// File: tb/test_trig_combine.sv
module test_trig_combine;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  trig_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mask_load = 1'b0;
    logic [63:0] mask_word = '0;
    logic        trig_pulse;
    logic [CW-1:0] pre_cnt, post_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_combine #(.CNT_W(CW)) i_trig_combine (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mask_load(mask_load), .mask_word(mask_word),
        .trig_pulse(trig_pulse), .pre_cnt(pre_cnt), .post_cnt(post_cnt)
    );

    // {expected pulse, pattern}; table bits set: 1, 8, 36, 63
    localparam logic [6:0] VEC [10] = '{
        {1'b1, 6'd1},  {1'b0, 6'd2},  {1'b1, 6'd8},  {1'b0, 6'd4},
        {1'b1, 6'd36}, {1'b0, 6'd32}, {1'b0, 6'd62}, {1'b1, 6'd63},
        {1'b0, 6'd9},  {1'b0, 6'd16}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #0.5;
        d = cfg_rdata;
    endtask

    // drive a pattern for one cycle, return the pulse seen after edge k+1
    task automatic shot(input logic [5:0] p, input string req, output logic seen);
        @(negedge clk);
        trig_in = p;
        @(negedge clk);
        chk({req, " no pulse before k+1"}, trig_pulse, 1'b0);
        @(negedge clk);
        seen = trig_pulse;
        trig_in = '0;
        @(negedge clk);
        chk("R6 pulse lasts one cycle", trig_pulse, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic        s;
        int          p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pulse", trig_pulse, 1'b0);
        chk("R1 pre", pre_cnt, 0);
        chk("R1 post", post_cnt, 0);
        rd(3'd0, r); chk("R1 mask lo", r, 0);
        rd(3'd1, r); chk("R1 mask hi", r, 0);
        rd(3'd2, r); chk("R1 veto set", r, 1);
        shot(6'd5, "R1", s);
        chk("R1 empty table no pulse", s, 1'b0);
        chk("R1 empty table no count", pre_cnt, 0);

        // R3 half writes
        wr(3'd0, 32'h0000_0102);
        wr(3'd1, 32'h8000_0010);
        rd(3'd0, r); chk("R3 low half", r, 32'h0000_0102);
        rd(3'd1, r); chk("R3 high half", r, 32'h8000_0010);

        // R7 veto set after reset
        shot(6'd8, "R7", s);
        chk("R7 veto blocks pulse", s, 1'b0);
        chk("R7 pre counts under veto", pre_cnt, 1);
        chk("R8 post not under veto", post_cnt, 0);

        // R11 veto clear and readback
        wr(3'd2, 32'h0);
        rd(3'd2, r); chk("R11 veto cleared", r, 0);
        wr(3'd3, 32'h0);
        chk("R10 clear pre", pre_cnt, 0);
        chk("R10 clear post", post_cnt, 0);

        // R2 vector table
        foreach (VEC[i]) begin
            shot(VEC[i][5:0], "R2", s);
            chk($sformatf("R2 pattern %0d", VEC[i][5:0]), s, VEC[i][6]);
        end
        chk("R8 post count after table", post_cnt, 4);
        chk("R5 pre count after table", pre_cnt, 4);

        // R5 held match counts once
        wr(3'd3, 32'h0);
        @(negedge clk);
        trig_in = 6'd36;
        p0 = 0;
        repeat (8) begin
            @(negedge clk);
            if (trig_pulse) p0++;
        end
        trig_in = '0;
        repeat (3) @(negedge clk);
        chk("R5 held match one pulse", p0, 1);
        chk("R5 held match pre", pre_cnt, 1);
        chk("R5 held match post", post_cnt, 1);

        // R4 full load wins over same-cycle half write
        @(negedge clk);
        mask_load = 1'b1; mask_word = 64'h0000_0000_0000_0004;
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        mask_load = 1'b0; cfg_we = 1'b0;
        rd(3'd0, r); chk("R4 full load low", r, 32'h4);
        rd(3'd1, r); chk("R4 full load high", r, 32'h0);
        shot(6'd2, "R4", s); chk("R4 new entry matches", s, 1'b1);
        shot(6'd1, "R4", s); chk("R4 old entry gone", s, 1'b0);

        // R10 clear beats increment
        @(negedge clk);
        trig_in = 6'd2;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        trig_in = '0;
        chk("R10 pulse still issued", trig_pulse, 1'b1);
        chk("R10 clear wins pre", pre_cnt, 0);
        chk("R10 clear wins post", post_cnt, 0);

        // R9 saturation
        repeat (20) begin
            @(negedge clk); trig_in = 6'd2;
            @(negedge clk); trig_in = 6'd0;
        end
        repeat (3) @(negedge clk);
        chk("R9 pre saturates", pre_cnt, 4'hF);
        chk("R9 post saturates", post_cnt, 4'hF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule